// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block times the two halves of the serial clock for a two-wire bus master. It runs from the system clock. A single configuration word sets the length of each half. The word holds one divider for the low half, one divider for the high half, and one power-of-two prescaler exponent shared by both. Each half lasts `divider * 2^exponent + OFFSET` system-clock cycles. OFFSET is a build parameter, normally 3 or 4. With equal dividers the resulting bus clock is `Fclk / (2 * (div * 2^exp + OFFSET))`. A 250 MHz system clock can therefore produce the usual 100 kHz rate as well as 400 kHz.

The block drives a request to pull SCL low, and it reads back the actual line level through `scl_in`. After a low half ends, the request is released. The high half is not counted until the line is actually seen high, so a slave that holds SCL low stretches the clock. Two one-cycle strobes mark the last cycle of each half. The surrounding bit engine uses these strobes to move data and to place start and stop conditions.

The configuration word is only taken in at the clock edge that starts a half. Lowering the enable returns the block to idle with the line released. The pin drivers, the bus protocol and any synchronizer for `scl_in` are outside this block. `scl_in` must already be synchronous to `clk`. The parameter `CK_MAX` must fit in `CK_W` bits.

Top module: `scl_wave_gen`

## Requirements
- R1: While enabled, each low half keeps `scl_pull_low` at 1 for exactly `lo_div * 2^e + OFFSET` cycles, where e is the effective exponent. `low_end_tick` is 1 only in the last of those cycles. In the cycle after that, `scl_pull_low` is 0.
- R2: If the line is not held, a high half of `hi_div * 2^e + OFFSET` cycles follows the one release cycle. `high_end_tick` falls on its last cycle, which is `hi_len + 1` cycles after the low strobe. A new low half starts in the next cycle.
- R3: The configuration word is split into three fields. Bits [7:0] hold the low-half divider. Bits [15:8] hold the high-half divider. Bits [18:16] hold the prescaler exponent. Each field affects only its own half.
- R4: An exponent field larger than `CK_MAX` acts exactly like `CK_MAX`. With the default `CK_MAX` = 5 and OFFSET = 3, dividers of 1 give halves of 35 cycles.
- R5: After a low half ends, the block waits with SCL released until `scl_in` is sampled at 1. The high count begins in the cycle after that sample. No `high_end_tick` and no pull request occur while waiting.
- R6: A change of the configuration word during a half does not alter that half. The change applies from the next half that starts.
- R7: In reset, `scl_pull_low`, `low_end_tick` and `high_end_tick` are 0. Neither strobe is ever 1 while `en` is 0. From the cycle after `en` is sampled 0, `scl_pull_low` stays 0, whatever `cfg_word` or `scl_in` do.
- R8: The first clock edge that samples `en` at 1 in idle starts a low half of full length. `scl_pull_low` is 1 from the next cycle.
- R9: The two strobes are never 1 in the same cycle. Each strobe lasts a single cycle per half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; 0 returns to idle with SCL released |
| cfg_word | input | 19 | Timing word: [7:0] low divider, [15:8] high divider, [18:16] exponent |
| scl_in | input | 1 | Sampled SCL line level, synchronous to clk |
| scl_pull_low | output | 1 | 1 requests the pad to drive SCL low |
| low_end_tick | output | 1 | One-cycle strobe on the last cycle of a low half |
| high_end_tick | output | 1 | One-cycle strobe on the last cycle of a high half |

## Verification
Some properties are checked on every cycle. The low half ends with the line released. A high strobe is followed by a new low half. Once started, the pull request stays asserted until its strobe. The enable acts as a quiet gate. The waiting window blocks the high strobe and the pull request, and the two strobes are exclusive. Exact phase lengths, the exponent clamp, the field positions and the rule that a new configuration word waits for the next half all depend on arithmetic over many cycles. Only the bench's reference model shows these, by comparing against it cycle by cycle and by measuring low-half lengths and strobe gaps in its scenarios.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_wave_scale.sv
// Phase length for one half: div shifted by the effective exponent, plus a fixed offset.
module scl_wave_scale #(
  parameter int DIV_W  = 8,
  parameter int CK_W   = 3,
  parameter int CK_MAX = 5,
  parameter int OFFSET = 3,
  parameter int CNT_W  = DIV_W + CK_MAX + 1
) (
  input  logic [DIV_W-1:0] div,
  input  logic [CK_W-1:0]  ck_eff,
  output logic [CNT_W-1:0] len
);
  logic [CNT_W-1:0] shifted [0:CK_MAX];
  logic [CNT_W-1:0] pick;

  genvar k;
  for (k = 0; k <= CK_MAX; k++) begin : g_shift
    assign shifted[k] = CNT_W'(div) << k;
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i <= CK_MAX; i++) begin
      if (ck_eff == CK_W'(i)) pick = shifted[i];
    end
  end

  assign len = pick + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_wave_decode.sv
// Splits the timing word, clamps the exponent and computes both half lengths.
module scl_wave_decode #(
  parameter int DIV_W  = 8,
  parameter int CK_W   = 3,
  parameter int CK_MAX = 5,
  parameter int OFFSET = 3,
  parameter int CNT_W  = DIV_W + CK_MAX + 1,
  parameter int CFG_W  = 2 * DIV_W + CK_W
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);
  localparam int NSIDE = 2;

  logic [CK_W-1:0]  ck_raw;
  logic [CK_W-1:0]  ck_eff;
  logic [CNT_W-1:0] lens [NSIDE];

  assign ck_raw = cfg[NSIDE*DIV_W +: CK_W];
  assign ck_eff = (ck_raw > CK_W'(CK_MAX)) ? CK_W'(CK_MAX) : ck_raw;

  genvar s;
  for (s = 0; s < NSIDE; s++) begin : g_side
    scl_wave_scale #(
      .DIV_W(DIV_W), .CK_W(CK_W), .CK_MAX(CK_MAX),
      .OFFSET(OFFSET), .CNT_W(CNT_W)
    ) u_scale (
      .div    (cfg[s*DIV_W +: DIV_W]),
      .ck_eff (ck_eff),
      .len    (lens[s])
    );
  end

  assign lo_len = lens[0];
  assign hi_len = lens[1];
endmodule

// File: rtl/scl_wave_counter.sv
// Loadable down-counter that holds at zero.
module scl_wave_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/scl_wave_gen.sv
// SCL phase timing generator: low half, release/wait-for-high, high half.
module scl_wave_gen
  import scl_wave_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CK_W   = 3,
  parameter int CK_MAX = 5,
  parameter int OFFSET = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [2*DIV_W+CK_W-1:0] cfg_word,
  input  logic                   scl_in,
  output logic                   scl_pull_low,
  output logic                   low_end_tick,
  output logic                   high_end_tick
);
  localparam int CFG_W = 2 * DIV_W + CK_W;
  localparam int CNT_W = DIV_W + CK_MAX + 1;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] lo_len, hi_len;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             load;
  logic             dec;
  logic [CNT_W-1:0] load_val;

  scl_wave_decode #(
    .DIV_W(DIV_W), .CK_W(CK_W), .CK_MAX(CK_MAX),
    .OFFSET(OFFSET), .CNT_W(CNT_W), .CFG_W(CFG_W)
  ) u_decode (
    .cfg    (cfg_word),
    .lo_len (lo_len),
    .hi_len (hi_len)
  );

  scl_wave_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  // Next phase and counter control; a half's length is latched only when it starts.
  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    dec      = 1'b0;
    load_val = '0;
    if (!en) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          load     = 1'b1;
          load_val = lo_len - CNT_W'(1);
        end
        PH_LOW: begin
          if (cnt_zero) phase_d = PH_WAIT;
          else          dec     = 1'b1;
        end
        PH_WAIT: begin
          if (scl_in) begin
            phase_d  = PH_HIGH;
            load     = 1'b1;
            load_val = hi_len - CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (cnt_zero) begin
            phase_d  = PH_LOW;
            load     = 1'b1;
            load_val = lo_len - CNT_W'(1);
          end else begin
            dec = 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign scl_pull_low  = (phase_q == PH_LOW);
  assign low_end_tick  = en && (phase_q == PH_LOW)  && cnt_zero;
  assign high_end_tick = en && (phase_q == PH_HIGH) && cnt_zero;
endmodule

// File: rtl/scl_wave_checks.sv
// Port-level properties of the SCL phase timing generator.
module scl_wave_checks (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_pull_low,
  input logic low_end_tick,
  input logic high_end_tick
);
  logic waiting;

  // Tracks the release window between a low strobe and the first high sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 waiting <= 1'b0;
    else if (!en)               waiting <= 1'b0;
    else if (low_end_tick)      waiting <= 1'b1;
    else if (waiting && scl_in) waiting <= 1'b0;
  end

  p_release_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    low_end_tick |=> !scl_pull_low);

  p_low_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_low && !low_end_tick && en) |=> scl_pull_low);

  p_low_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    high_end_tick |=> scl_pull_low);

  p_stretch_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!high_end_tick && !scl_pull_low));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !low_end_tick && !high_end_tick));

  p_no_tick_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> !low_end_tick);

  p_ticks_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_end_tick, high_end_tick}));
endmodule

bind scl_wave_gen scl_wave_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .scl_in        (scl_in),
  .scl_pull_low  (scl_pull_low),
  .low_end_tick  (low_end_tick),
  .high_end_tick (high_end_tick)
);

// File: tb/tb_scl_wave_gen.sv
`timescale 1ns/1ps
module tb_scl_wave_gen;
  localparam int OFF   = 3;
  localparam int CKMAX = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        hold = 1'b0;
  logic [18:0] cfg = '0;
  logic        scl_pull_low, lo_t, hi_t;
  logic        scl_in;

  always #2 clk = ~clk;  // 250 MHz

  // Open-drain line: low when the block or the slave pulls it.
  assign scl_in = !scl_pull_low && !hold;

  scl_wave_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg), .scl_in(scl_in),
    .scl_pull_low(scl_pull_low), .low_end_tick(lo_t), .high_end_tick(hi_t)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R8";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int plen(input int d, input int ck);
    int c;
    c = (ck > CKMAX) ? CKMAX : ck;
    return d * (1 << c) + OFF;
  endfunction

  // R3: field positions [7:0] low, [15:8] high, [18:16] exponent.
  function automatic logic [18:0] mk(input int lo, input int hi, input int ck);
    logic [7:0] l8, h8;
    logic [2:0] c3;
    l8 = lo[7:0];
    h8 = hi[7:0];
    c3 = ck[2:0];
    return {c3, h8, l8};
  endfunction

  // Behavioural reference: 0 idle, 1 low, 2 released waiting, 3 high.
  int m_st = 0;
  int m_left = 0;
  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_left = plen(int'(cfg[7:0]), int'(cfg[18:16])); end
        1: if (m_left == 1) m_st = 2; else m_left--;
        2: if (scl_in) begin m_st = 3; m_left = plen(int'(cfg[15:8]), int'(cfg[18:16])); end
        default: if (m_left == 1) begin
                   m_st = 1; m_left = plen(int'(cfg[7:0]), int'(cfg[18:16]));
                 end else m_left--;
      endcase
    end
  end

  // Per-cycle comparison and measurements, away from the active edge.
  int cyc = 0, run = 0, last_low = 0, nlow = 0, t_lo = 0, last_gap = 0;
  int hi_hold = 0, both = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk({cur_req, " pull"}, int'(scl_pull_low), int'(m_st == 1));
      chk({cur_req, " lotick"}, int'(lo_t), int'(en && m_st == 1 && m_left == 1));
      chk({cur_req, " hitick"}, int'(hi_t), int'(en && m_st == 3 && m_left == 1));
      if (scl_pull_low) run++;
      else if (run > 0) begin last_low = run; run = 0; nlow++; end
      if (lo_t) t_lo = cyc;
      if (hi_t) last_gap = cyc - t_lo;
      if (hi_t && hold) hi_hold++;
      if (hi_t && lo_t) both++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_lows(input int k);
    int target;
    target = nlow + k;
    while (nlow < target) step(1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL all watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    cfg = mk(2, 1, 1);
    step(3);
    @(negedge clk);
    chk("R7 reset", int'({scl_pull_low, lo_t, hi_t}), 0);
    rst_n = 1'b1;
    step(2);

    // R8: enable starts a full low half
    en = 1'b1;
    @(negedge clk);
    chk("R8 before edge", int'(scl_pull_low), 0);
    step(1);
    @(negedge clk);
    chk("R8 after edge", int'(scl_pull_low), 1);

    // R1 / R2: lo=2 hi=1 e=1 -> 7 and 5
    cur_req = "R1";
    wait_lows(3);
    chk("R1 low len", last_low, 7);
    chk("R2 gap", last_gap, 6);

    // R3: asymmetric fields lo=5 hi=0 e=0 -> 8 and 3
    cur_req = "R3";
    cfg = mk(5, 0, 0);
    wait_lows(3);
    chk("R3 low len", last_low, 8);
    chk("R3 gap", last_gap, 4);

    // R4: exponent 7 and 6 clamp to 5
    cur_req = "R4";
    cfg = mk(1, 1, 7);
    wait_lows(3);
    chk("R4 low len e7", last_low, 35);
    chk("R4 gap e7", last_gap, 36);
    cfg = mk(1, 1, 6);
    wait_lows(2);
    chk("R4 low len e6", last_low, 35);

    // R5: slave stretches the clock by holding the line during release
    cur_req = "R5";
    cfg = mk(3, 2, 0);
    wait_lows(2);
    while (scl_pull_low) step(1);
    while (!scl_pull_low) step(1);
    hold = 1'b1;
    while (scl_pull_low) step(1);
    step(12);
    hold = 1'b0;
    wait_lows(1);
    chk("R5 stretched gap", last_gap, 18);
    chk("R5 high tick while held", hi_hold, 0);

    // R6: change mid-phase applies from the next half
    cur_req = "R6";
    cfg = mk(4, 4, 0);
    wait_lows(2);
    while (scl_pull_low) step(1);
    while (!scl_pull_low) step(1);
    step(2);
    cfg = mk(20, 20, 0);
    wait_lows(1);
    chk("R6 current half", last_low, 7);
    wait_lows(1);
    chk("R6 next half", last_low, 23);

    // R7: disable mid low half, then stimulus has no effect
    cur_req = "R7";
    while (!scl_pull_low) step(1);
    step(3);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      cfg = mk(i, 3 * i, i % 8);
      hold = (i % 3 == 0);
      @(negedge clk);
      chk("R7 disabled outputs", int'({scl_pull_low, lo_t, hi_t}), 0);
    end
    hold = 1'b0;

    // R8: re-enable gives a full low half with the new word
    cur_req = "R8";
    cfg = mk(6, 2, 1);
    en = 1'b1;
    step(1);
    @(negedge clk);
    chk("R8 re-enable pull", int'(scl_pull_low), 1);
    wait_lows(1);
    chk("R8 first low len", last_low, 15);

    // R1: 100 kHz and 400 kHz settings at 250 MHz
    cur_req = "R1";
    cfg = mk(156, 155, 3);
    wait_lows(2);
    chk("R1 100k low len", last_low, 1251);
    chk("R2 100k gap", last_gap, 1244);
    cfg = mk(39, 38, 3);
    wait_lows(2);
    chk("R1 400k low len", last_low, 315);
    chk("R2 400k gap", last_gap, 308);

    chk("R9 simultaneous strobes", both, 0);
    step(2);
    summary();
    $finish;
  end
endmodule